// File: doc/BRIEF.md
# Serial Converter Emulator (16-bit, three-wire readout)

This block stands in for the digital face of a 16-bit successive-approximation converter. A controller under test drives a convert-start line and a serial clock; the emulator answers on a serial data line. The word it returns comes from a parallel sample input. Because the readout follows the real part's timing rules, a converter controller can be exercised in simulation or on a board without the physical chip.

The emulator runs on its own system clock. It oversamples the convert-start and serial-clock lines through synchronizers, so the two clocks may have any phase relationship. A rising edge on convert-start freezes the sample word and opens a conversion window of a fixed number of system cycles. The window is typically set to 300 to 500 ns. Once the window closes, sixteen serial-clock cycles shift the word out, most significant bit first. The controller may keep convert-start high during the readout or drop it once the window has closed. A sticky error flag marks serial-clock activity inside the conversion window. A done pulse and a wrapping readout counter help a test bench. The sample input is a plain level input read at the convert edge. It is not a stream, so it has no valid/ready handshake and no back-pressure.

Top module: `adc_serial_emulator`

## Requirements
- R1: After reset, sdo_o, err_o and done_o are 0 and readouts_o is 0.
- R2: While convert-start is low and no conversion is pending, serial-clock edges have no effect: sdo_o stays 0, no done pulse occurs, readouts_o and err_o are unchanged, and the next readout is intact.
- R3: A synchronized rising edge of cnv_i captures sample_i. Changes to sample_i after that edge do not alter the word read out.
- R4: Conversion lasts CONV_CYCLES system cycles after the convert edge is detected. Any serial-clock edge seen in that window sets err_o to 1. err_o stays 1 until reset, and such edges do not shift data.
- R5: After conversion, each of 16 serial-clock rising edges puts the next word bit on sdo_o, bit 15 first and bit 0 last. Each bit appears within SYNC_STAGES+1 system cycles and holds until the next rising edge, so it is valid at the falling edge.
- R6: sdo_o is 0 outside the readout window, both before the first rising edge after conversion and after the 16th falling edge.
- R7: The readout is correct whether cnv_i stays high throughout or is driven low after the conversion window has closed.
- R8: The 16th serial-clock falling edge of a readout produces exactly one done_o pulse, one system cycle long. readouts_o increments by one in the same cycle and wraps at 2^CNT_W.
- R9: After a readout with cnv_i still high, further serial-clock edges are ignored until cnv_i goes low. The next conversion then starts on the following rising edge of cnv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulator system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_i | input | 1 | Convert-start line from the controller (asynchronous) |
| sck_i | input | 1 | Serial clock from the controller (asynchronous) |
| sample_i | input | DATA_W | Word to be returned, read at the convert edge |
| sdo_o | output | 1 | Serial data to the controller |
| err_o | output | 1 | Sticky flag: serial clock seen during conversion |
| done_o | output | 1 | One-cycle pulse when a readout completes |
| readouts_o | output | CNT_W | Count of completed readouts, wrapping |

## Verification
A wrong phase register shows at the ports within one serial-clock period. A stuck phase either keeps sdo_o at 0 during a readout, which corrupts the compared word, or drives bits outside the window, which the idle-level checks catch. A bit counter off by one shows in the same transaction, as a shifted word or a missing or extra done pulse. The readout counter then falls out of step with the bench's own tally. An error flag that fails to latch or fails to hold is exposed by the probe transaction and by the transaction after it.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;
  typedef enum logic [1:0] {
    PH_ACQ  = 2'd0,
    PH_CONV = 2'd1,
    PH_READ = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;
endpackage

// File: rtl/adc_emu_edge_sync.sv
module adc_emu_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic edge_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/adc_emu_conv_timer.sv
module adc_emu_conv_timer #(
  parameter int CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [TW-1:0] LOAD = TW'(CYCLES - 1);

  logic [TW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      left_q <= '0;
    else if (start_i)                left_q <= LOAD;
    else if (run_i && left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign expire_o = run_i && (left_q == '0);
endmodule

// File: rtl/adc_emu_shifter.sv
module adc_emu_shifter #(
  parameter int W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [W-1:0]             data_i,
  input  logic                     shift_i,
  input  logic                     clear_i,
  output logic                     sdo_o,
  output logic [$clog2(W+1)-1:0]   bits_o
);
  localparam int BW = $clog2(W + 1);

  logic [W-1:0]  word_q;
  logic          sdo_q;
  logic [BW-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      sdo_q  <= 1'b0;
      bits_q <= '0;
    end else if (load_i) begin
      word_q <= data_i;
      sdo_q  <= 1'b0;
      bits_q <= '0;
    end else if (shift_i) begin
      sdo_q  <= word_q[W-1];
      word_q <= {word_q[W-2:0], 1'b0};
      bits_q <= bits_q + 1'b1;
    end else if (clear_i) begin
      sdo_q  <= 1'b0;
    end
  end

  assign sdo_o  = sdo_q;
  assign bits_o = bits_q;
endmodule

// File: rtl/adc_serial_emulator.sv
module adc_serial_emulator #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 25,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnv_i,
  input  logic              sck_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              sdo_o,
  output logic              err_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  readouts_o
);
  import adc_emu_pkg::*;

  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [BW-1:0] LAST = BW'(DATA_W);

  logic cnv_lvl, cnv_edge, sck_lvl, sck_edge;
  logic cnv_rise, sck_rise, sck_fall;
  logic conv_over, load, shift, last_fall;
  logic [BW-1:0] bits;
  phase_t phase_q, phase_d;
  logic err_q, done_q;
  logic [CNT_W-1:0] count_q;

  adc_emu_edge_sync #(.STAGES(SYNC_STAGES)) u_cnv_sync (
    .clk(clk), .rst_n(rst_n), .din(cnv_i), .level_o(cnv_lvl), .edge_o(cnv_edge)
  );
  adc_emu_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .din(sck_i), .level_o(sck_lvl), .edge_o(sck_edge)
  );

  assign cnv_rise = cnv_edge & cnv_lvl;
  assign sck_rise = sck_edge & sck_lvl;
  assign sck_fall = sck_edge & ~sck_lvl;

  assign load      = (phase_q == PH_ACQ) && cnv_rise;
  assign shift     = (phase_q == PH_READ) && sck_rise && (bits < LAST);
  assign last_fall = (phase_q == PH_READ) && sck_fall && (bits == LAST);

  adc_emu_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(load),
    .run_i(phase_q == PH_CONV), .expire_o(conv_over)
  );

  adc_emu_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(sample_i),
    .shift_i(shift), .clear_i(last_fall), .sdo_o(sdo_o), .bits_o(bits)
  );

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_ACQ:  if (cnv_rise)  phase_d = PH_CONV;
      PH_CONV: if (conv_over) phase_d = PH_READ;
      PH_READ: if (last_fall) phase_d = cnv_lvl ? PH_HOLD : PH_ACQ;
      PH_HOLD: if (!cnv_lvl)  phase_d = PH_ACQ;
      default: phase_d = PH_ACQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ACQ;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      count_q <= '0;
    end else begin
      phase_q <= phase_d;
      done_q  <= last_fall;
      if ((phase_q == PH_CONV) && sck_edge) err_q <= 1'b1;
      if (last_fall) count_q <= count_q + 1'b1;
    end
  end

  assign err_o      = err_q;
  assign done_o     = done_q;
  assign readouts_o = count_q;
endmodule

// File: rtl/adc_emu_checker.sv
module adc_emu_checker #(
  parameter int CNT_W = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input adc_emu_pkg::phase_t   phase,
  input logic                  sdo_o,
  input logic                  err_o,
  input logic                  done_o,
  input logic [CNT_W-1:0]      readouts_o
);
  import adc_emu_pkg::*;

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  assert_err_from_conv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> ($past(phase) == PH_CONV));

  assert_sdo_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_READ) |-> !sdo_o);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (readouts_o == CNT_W'($past(readouts_o) + 1'b1)));

  assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(readouts_o));
endmodule

bind adc_serial_emulator adc_emu_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .phase(phase_q), .sdo_o(sdo_o),
  .err_o(err_o), .done_o(done_o), .readouts_o(readouts_o)
);

// File: tb/adc_serial_emulator_test.sv
module adc_serial_emulator_test;
  localparam int W = 16;
  localparam int CONV = 25;
  localparam int CNT_W = 8;
  localparam int NVEC = 6;
  // each vector: {drop cnv after conversion, sample word}
  localparam logic [W:0] VEC [NVEC] = '{
    {1'b0, 16'hA5C3}, {1'b1, 16'h0000}, {1'b0, 16'hFFFF},
    {1'b1, 16'h8001}, {1'b0, 16'h7FFE}, {1'b1, 16'h1234}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b0;
  logic sck = 1'b0;
  logic [W-1:0] sample = '0;
  logic sdo, err, done;
  logic [CNT_W-1:0] readouts;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  int exp_count = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  adc_serial_emulator #(.DATA_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(2), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck), .sample_i(sample),
    .sdo_o(sdo), .err_o(err), .done_o(done), .readouts_o(readouts)
  );

  always @(negedge clk) if (rst_n && done) done_seen++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(output logic b);
    sck = 1'b1; #90; b = sdo; #10;
    sck = 1'b0; #100;
  endtask

  task automatic transact(input logic [W-1:0] s, input bit drop, input bit poke,
                          input int extra, output logic [W-1:0] word);
    logic b;
    int d0;
    d0 = done_seen;
    sample = s; #20;
    cnv = 1'b1; #100;
    sample = ~s;                       // R3: late change must not reach the word
    if (poke) begin
      sck = 1'b1; #60; sck = 1'b0; #60; // R4: edges inside conversion
      #480;
    end else #600;
    if (drop) cnv = 1'b0;
    #40;
    check(sdo == 1'b0, "R6", "sdo before first edge", sdo, 0);
    word = '0;
    for (int i = 0; i < W; i++) begin
      pulse(b);
      word = {word[W-2:0], b};
    end
    #100;
    check(sdo == 1'b0, "R6", "sdo after readout", sdo, 0);
    exp_count++;
    check(done_seen - d0 == 1, "R8", "done pulses", done_seen - d0, 1);
    check(readouts == CNT_W'(exp_count), "R8", "readout count", readouts, CNT_W'(exp_count));
    for (int i = 0; i < extra; i++) begin
      pulse(b);
      check(b == 1'b0, "R9", "sdo in hold", b, 0);
    end
    if (extra > 0) begin
      #100;
      check(done_seen - d0 == 1, "R9", "done in hold", done_seen - d0, 1);
      check(readouts == CNT_W'(exp_count), "R9", "count in hold", readouts, CNT_W'(exp_count));
    end
    cnv = 1'b0; #200;
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] word;
    logic b;
    #103;
    check({sdo, err, done} == 3'b000, "R1", "outputs after reset", {sdo, err, done}, 0);
    check(readouts == '0, "R1", "count after reset", readouts, 0);
    rst_n = 1'b1; #200;

    for (int v = 0; v < NVEC; v++) begin
      transact(VEC[v][W-1:0], VEC[v][W], 1'b0, 0, word);
      check(word == VEC[v][W-1:0], VEC[v][W] ? "R7" : "R5", "word", word, VEC[v][W-1:0]);
      check(err == 1'b0, "R4", "no false error", err, 0);
    end

    // R2: serial clock while idle
    for (int i = 0; i < 5; i++) begin
      pulse(b);
      check(b == 1'b0, "R2", "sdo idle", b, 0);
    end
    check(readouts == CNT_W'(exp_count) && err == 1'b0, "R2", "count/err idle",
          {err, readouts}, CNT_W'(exp_count));
    transact(16'hC0DE, 1'b0, 1'b0, 0, word);
    check(word == 16'hC0DE, "R2", "word after idle clocks", word, 16'hC0DE);

    // R9: extra clocks while cnv held high after readout, then new conversion
    transact(16'h5A5A, 1'b0, 1'b0, 4, word);
    check(word == 16'h5A5A, "R9", "word before hold", word, 16'h5A5A);
    transact(16'h0F0F, 1'b1, 1'b0, 0, word);
    check(word == 16'h0F0F, "R9", "next conversion", word, 16'h0F0F);

    // R4: clock during conversion
    transact(16'hBEEF, 1'b0, 1'b1, 0, word);
    check(err == 1'b1, "R4", "error flagged", err, 1);
    check(word == 16'hBEEF, "R4", "word not shifted by early edges", word, 16'hBEEF);
    transact(16'h3C3C, 1'b1, 1'b0, 0, word);
    check(err == 1'b1, "R4", "error sticky", err, 1);
    check(word == 16'h3C3C, "R3", "captured word", word, 16'h3C3C);

    rst_n = 1'b0; #100;
    check({sdo, err, done} == 3'b000, "R1", "outputs after second reset", {sdo, err, done}, 0);
    check(readouts == '0, "R1", "count after second reset", readouts, 0);
    rst_n = 1'b1; #100;

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule